// File: doc/BRIEF.md
# Branch Target Cache with Mode-Selective Flush

This block is a small direct-mapped cache of resolved branches. The fetch stage presents a fetch address on the lookup port. One clock later the block reports whether a stored branch matches that address, the branch's destination, and whether a 2-bit saturating counter currently predicts it as taken. The execute stage reports each resolved branch on the update port. It gives the branch address, the destination, the outcome, and the privilege level the processor was running at.

Each stored entry records the privilege level that created it. A control write can therefore discard every entry, or only the entries created in user mode, while supervisor entries stay usable. The control port also holds a single enable bit. While the enable bit is clear, the cache neither predicts nor learns. Reset clears the enable bit but leaves the stored contents alone. Software is expected to issue a flush-everything command before it first enables the cache.

Top module: `branch_target_cache`

## Requirements
- R1: While the enable bit is 0, every lookup reports `lk_hit`=0, `lk_taken`=0 and `lk_target`=0, and updates change no entry.
- R2: While enabled, a taken branch that misses is stored with its counter at 2 (weakly taken). A later lookup of the same address reports hit=1, taken=1 and the stored target.
- R3: A control write with `cfg_clr_all`=1 invalidates every entry.
- R4: A control write with `cfg_clr_user`=1 invalidates exactly the entries stored with `upd_super`=0. Entries stored with `upd_super`=1 keep hitting.
- R5: `cfg_status` bit 0 reads back the enable bit. Bits 1 (flush-all) and 2 (flush-user) always read 0. A control write with both command bits at 0 changes no entry.
- R6: Reset clears the enable bit, so `cfg_status` reads 0, but keeps stored entries. After re-enabling without a flush, an entry stored before reset hits again.
- R7: A lookup presented in the same cycle as either flush command reports a miss.
- R8: When a flush and an update arrive in the same cycle, the flush wins for entries it covers. A user-mode update during flush-user, or any update during flush-all, leaves no valid entry. A supervisor update during flush-user is stored.
- R9: An update that hits moves the entry's counter up (taken) or down (not taken), saturating at 3 and 0. `lk_taken` is counter bit 1. A hit with counter 0 or 1 reports hit=1 and taken=0. A taken hit replaces the target; a not-taken hit keeps it.
- R10: Lookup results appear on the clock edge after the address is presented. The index is `lk_addr[3:0]` and the tag is the remaining upper bits. An address sharing the index but not the tag misses. On a miss, `lk_target` is 0.
- R11: A not-taken branch that misses allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the enable bit and the lookup outputs only |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable value to store on a control write |
| cfg_clr_all | input | 1 | Write-one command: invalidate all entries |
| cfg_clr_user | input | 1 | Write-one command: invalidate user-mode entries |
| cfg_status | output | 3 | Read-back: bit 0 enable, bits 2:1 always 0 |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Registered: a stored branch matched |
| lk_taken | output | 1 | Registered: matched branch predicted taken |
| lk_target | output | 32 | Registered: predicted destination, 0 on miss |
| upd_valid | input | 1 | Resolved-branch report strobe |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Destination of the resolved branch |
| upd_taken | input | 1 | Branch outcome |
| upd_super | input | 1 | 1 if the branch ran in supervisor mode |

## Verification
The bench targets the same-cycle collisions. It issues a flush together with a lookup, a flush together with a user-mode update, and a flush together with a supervisor-mode update. A design with the priority reversed would leave a live user entry after a flush, or would drop a supervisor branch it should have kept. The bench also walks one entry's counter through both saturation limits. An off-by-one or wrapping counter would flip the taken prediction at the wrong step, and a not-taken hit that rewrites the target would show a changed destination. Finally it resets with a live entry and re-enables without a flush. A design that wipes its contents on reset, or keeps the enable bit set through reset, shows up at once in that sequence.

// File: rtl/btc_pkg.sv
package btc_pkg;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    if (taken) r = (c == 2'b11) ? c : c + 2'b01;
    else       r = (c == 2'b00) ? c : c - 2'b01;
    return r;
  endfunction

endpackage

// File: rtl/btc_ctrl.sv
module btc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       cfg_clr_all,
  input  logic       cfg_clr_user,
  output logic       en_o,
  output logic       flush_all_o,
  output logic       flush_user_o,
  output logic [2:0] status_o
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (cfg_wr) en_q <= cfg_en;
  end

  assign en_o         = en_q;
  assign flush_all_o  = cfg_wr & cfg_clr_all;
  assign flush_user_o = cfg_wr & cfg_clr_user;
  assign status_o     = {2'b00, en_q};

  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (en_q == $past(cfg_en)));               // R5
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(en_q));                         // R5

endmodule

// File: rtl/btc_store.sv
module btc_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              flush_all,
  input  logic              flush_user,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_super,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_tgt,
  output logic [1:0]        rd_ctr
);
  import btc_pkg::*;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] super_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];
  logic [1:0]         ctr_mem [ENTRIES];

  logic [IDX_W-1:0] u_idx;
  logic [TAG_W-1:0] u_tag;
  logic             u_hit;
  logic             u_want;
  logic             u_blocked;
  logic             u_wr;
  logic [1:0]       u_ctr;
  logic             u_tgt_wr;

  assign u_idx     = upd_addr[IDX_W-1:0];
  assign u_tag     = upd_addr[ADDR_W-1:IDX_W];
  assign u_hit     = valid_q[u_idx] && (tag_mem[u_idx] == u_tag);
  assign u_want    = en && upd_valid && (u_hit || upd_taken);
  assign u_blocked = flush_all || (flush_user && !upd_super);
  assign u_wr      = u_want && !u_blocked;
  assign u_ctr     = u_hit ? ctr_step(ctr_mem[u_idx], upd_taken) : CTR_WEAK_TAKEN;
  assign u_tgt_wr  = u_wr && (!u_hit || upd_taken);

  // Per-entry valid and mode flags; reset leaves them untouched.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (u_wr && (u_idx == IDX_W'(i))) begin
        valid_q[i] <= 1'b1;
        super_q[i] <= upd_super;
      end else if (flush_all || (flush_user && !super_q[i])) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  // Payload arrays: one write port, no reset, RAM-style.
  always_ff @(posedge clk) begin
    if (u_wr) begin
      tag_mem[u_idx] <= u_tag;
      ctr_mem[u_idx] <= u_ctr;
    end
    if (u_tgt_wr) tgt_mem[u_idx] <= upd_target;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_tgt   = tgt_mem[rd_idx];
  assign rd_ctr   = ctr_mem[rd_idx];

  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_q == '0));                                    // R3
  AST_FLUSH_USER_KILLS: assert property (@(posedge clk) disable iff (rst)
    flush_user |=> ((valid_q & ~super_q) == '0));                      // R4
  AST_FLUSH_USER_SPARES: assert property (@(posedge clk) disable iff (rst)
    (flush_user && !flush_all) |=> ((valid_q & super_q & $past(valid_q & super_q))
                                    == $past(valid_q & super_q)));     // R4
  AST_OFF_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush_all && !flush_user) |=> $stable(valid_q));          // R1

endmodule

// File: rtl/btc_lookup.sv
module btc_lookup #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              flushing,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_tgt,
  input  logic [1:0]        rd_ctr,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);

  logic match;

  assign rd_idx = lk_addr[IDX_W-1:0];
  assign match  = en && lk_valid && !flushing && rd_valid &&
                  (rd_tag == lk_addr[ADDR_W-1:IDX_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o    <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
    end else begin
      hit_o    <= match;
      taken_o  <= match && rd_ctr[1];
      target_o <= match ? rd_tgt : '0;
    end
  end

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> hit_o);                                                // R9
  AST_MISS_ZERO_TARGET: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (target_o == '0));                                      // R10
  AST_FLUSH_LOOKUP_MISS: assert property (@(posedge clk) disable iff (rst)
    flushing |=> !hit_o);                                              // R7
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !en |=> !hit_o);                                                   // R1

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_clr_all,
  input  logic              cfg_clr_user,
  output logic [2:0]        cfg_status,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_super
);

  logic              en;
  logic              flush_all;
  logic              flush_user;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_tgt;
  logic [1:0]        rd_ctr;

  btc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_en       (cfg_en),
    .cfg_clr_all  (cfg_clr_all),
    .cfg_clr_user (cfg_clr_user),
    .en_o         (en),
    .flush_all_o  (flush_all),
    .flush_user_o (flush_user),
    .status_o     (cfg_status)
  );

  btc_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_store (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .flush_all  (flush_all),
    .flush_user (flush_user),
    .upd_valid  (upd_valid),
    .upd_addr   (upd_addr),
    .upd_target (upd_target),
    .upd_taken  (upd_taken),
    .upd_super  (upd_super),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_tgt     (rd_tgt),
    .rd_ctr     (rd_ctr)
  );

  btc_lookup #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lookup (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .flushing (flush_all | flush_user),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_tgt   (rd_tgt),
    .rd_ctr   (rd_ctr),
    .hit_o    (lk_hit),
    .taken_o  (lk_taken),
    .target_o (lk_target)
  );

  AST_STATUS_CMDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (cfg_status[2:1] == 2'b00));                            // R5

endmodule

// File: tb/branch_target_cache_test.sv
`timescale 1ns/1ps
module branch_target_cache_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_en, cfg_clr_all, cfg_clr_user;
  logic [2:0]  cfg_status;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        upd_valid;
  logic [31:0] upd_addr, upd_target;
  logic        upd_taken, upd_super;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  branch_target_cache uut (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_clr_all(cfg_clr_all),
    .cfg_clr_user(cfg_clr_user), .cfg_status(cfg_status),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_taken(lk_taken), .lk_target(lk_target),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_super(upd_super)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; cfg_en = 0; cfg_clr_all = 0; cfg_clr_user = 0;
    lk_valid = 0; lk_addr = '0;
    upd_valid = 0; upd_addr = '0; upd_target = '0; upd_taken = 0; upd_super = 0;
  endtask

  task automatic ctl(input logic en, input logic ca, input logic cu);
    cfg_wr = 1; cfg_en = en; cfg_clr_all = ca; cfg_clr_user = cu;
    tick();
    cfg_wr = 0; cfg_clr_all = 0; cfg_clr_user = 0;
  endtask

  task automatic upd(input logic [31:0] a, input logic [31:0] t,
                     input logic tk, input logic sv);
    upd_valid = 1; upd_addr = a; upd_target = t; upd_taken = tk; upd_super = sv;
    tick();
    upd_valid = 0;
  endtask

  task automatic look(input string req, input logic [31:0] a,
                      input logic eh, input logic et, input logic [31:0] etg);
    lk_valid = 1; lk_addr = a;
    tick();
    lk_valid = 0;
    chk(req, "hit", 32'(lk_hit), 32'(eh));
    chk(req, "taken", 32'(lk_taken), 32'(et));
    chk(req, "target", lk_target, etg);
  endtask

  task automatic t_reset_state();
    chk("R6", "status after reset", 32'(cfg_status), 32'd0);
    look("R1", 32'h0000_1000, 0, 0, 32'h0);
  endtask

  task automatic t_disabled();
    ctl(0, 1, 0);                                // flush while off
    upd(32'h0000_2003, 32'h0000_9000, 1, 0);     // must not allocate
    ctl(1, 0, 0);
    chk("R5", "status enable only", 32'(cfg_status), 32'd1);
    look("R1", 32'h0000_2003, 0, 0, 32'h0);
  endtask

  task automatic t_alloc();
    upd(32'h0000_4004, 32'h0000_8800, 1, 0);
    look("R2", 32'h0000_4004, 1, 1, 32'h0000_8800);
    look("R10", 32'h0001_4004, 0, 0, 32'h0);     // same index, other tag
    upd(32'h0000_4107, 32'h0000_7700, 0, 0);
    look("R11", 32'h0000_4107, 0, 0, 32'h0);
  endtask

  task automatic t_counter();
    logic [31:0] a = 32'h0000_4004;
    upd(a, 32'h0000_1111, 1, 0);                 // 2->3, target replaced
    upd(a, 32'h0000_1111, 1, 0);                 // stays 3
    upd(a, 32'h0000_DEAD, 0, 0);                 // 3->2, target kept
    look("R9", a, 1, 1, 32'h0000_1111);
    upd(a, 32'h0000_DEAD, 0, 0);                 // 2->1
    look("R9", a, 1, 0, 32'h0000_1111);
    upd(a, 32'h0000_DEAD, 0, 0);                 // 1->0
    upd(a, 32'h0000_DEAD, 0, 0);                 // stays 0
    upd(a, 32'h0000_2222, 1, 0);                 // 0->1
    look("R9", a, 1, 0, 32'h0000_2222);
    upd(a, 32'h0000_2222, 1, 0);                 // 1->2
    look("R9", a, 1, 1, 32'h0000_2222);
  endtask

  task automatic t_flush_user();
    upd(32'h0000_0005, 32'h0000_5500, 1, 0);
    upd(32'h0000_0006, 32'h0000_6600, 1, 1);
    ctl(1, 0, 1);
    chk("R5", "cmd bits read zero", 32'(cfg_status), 32'd1);
    look("R4", 32'h0000_0005, 0, 0, 32'h0);
    look("R4", 32'h0000_0006, 1, 1, 32'h0000_6600);
  endtask

  task automatic t_zero_cmd();
    ctl(1, 0, 0);
    look("R5", 32'h0000_0006, 1, 1, 32'h0000_6600);
  endtask

  task automatic t_flush_all();
    ctl(1, 1, 0);
    look("R3", 32'h0000_0006, 0, 0, 32'h0);
    look("R3", 32'h0000_4004, 0, 0, 32'h0);
  endtask

  task automatic t_same_cycle_lookup();
    upd(32'h0000_0009, 32'h0000_9900, 1, 1);
    cfg_wr = 1; cfg_en = 1; cfg_clr_user = 1;    // spares the supervisor entry
    lk_valid = 1; lk_addr = 32'h0000_0009;
    tick();
    cfg_wr = 0; cfg_clr_user = 0; lk_valid = 0;
    chk("R7", "hit during flush", 32'(lk_hit), 32'd0);
    look("R4", 32'h0000_0009, 1, 1, 32'h0000_9900);
  endtask

  task automatic t_priority();
    cfg_wr = 1; cfg_en = 1; cfg_clr_user = 1;
    upd_valid = 1; upd_addr = 32'h0000_000A; upd_target = 32'h0000_AA00;
    upd_taken = 1; upd_super = 0;
    tick();
    upd_addr = 32'h0000_000B; upd_target = 32'h0000_BB00; upd_super = 1;
    tick();
    cfg_clr_user = 0; cfg_clr_all = 1;
    upd_addr = 32'h0000_000C; upd_target = 32'h0000_CC00;
    tick();
    cfg_wr = 0; cfg_clr_all = 0; upd_valid = 0;
    look("R8", 32'h0000_000A, 0, 0, 32'h0);
    look("R8", 32'h0000_000B, 0, 0, 32'h0);      // removed by the flush-all cycle
    look("R8", 32'h0000_000C, 0, 0, 32'h0);
    cfg_wr = 1; cfg_en = 1; cfg_clr_user = 1;
    upd_valid = 1; upd_addr = 32'h0000_000D; upd_target = 32'h0000_DD00;
    upd_taken = 1; upd_super = 1;
    tick();
    cfg_wr = 0; cfg_clr_user = 0; upd_valid = 0;
    look("R8", 32'h0000_000D, 1, 1, 32'h0000_DD00);
  endtask

  task automatic t_disable_hides();
    ctl(0, 0, 0);
    look("R1", 32'h0000_000D, 0, 0, 32'h0);
    upd(32'h0000_000E, 32'h0000_EE00, 1, 1);
    ctl(1, 0, 0);
    look("R1", 32'h0000_000E, 0, 0, 32'h0);
    look("R1", 32'h0000_000D, 1, 1, 32'h0000_DD00);
  endtask

  task automatic t_reset_keeps();
    rst = 1; tick(); tick(); rst = 0;
    chk("R6", "status after second reset", 32'(cfg_status), 32'd0);
    look("R6", 32'h0000_000D, 0, 0, 32'h0);
    ctl(1, 0, 0);
    look("R6", 32'h0000_000D, 1, 1, 32'h0000_DD00);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_disabled();
    t_alloc();
    t_counter();
    t_flush_user();
    t_zero_cmd();
    t_flush_all();
    t_same_cycle_lookup();
    t_priority();
    t_disable_hides();
    t_reset_keeps();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule